// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command interface of a byte-wide flash memory whose cell array is modelled as a small bank of registers. A host talks to it through asynchronous memory-style pins: an active-low chip enable, write enable and output enable, an address bus, and a bidirectional data bus. Each write cycle carries a byte into the command register. The controller decodes that byte and steps through a fixed sequence: program setup, an address-and-data write, a timed internal program step, and a verify read-back of the byte just written.

All pins are sampled into the internal clock domain before any edge is detected. A write cycle counts once, when the combined chip-enable/write-enable strobe ends. Address and data come from the bus as seen at that moment. The program step can only clear bits. The address captured by the program write is held until the verify is finished. Two back-to-back all-ones writes cancel any program or erase sequence and return to read mode. An erase setup command is decoded only so that it can be cancelled; it performs no erase.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the controller is in read mode and every array byte holds FFh.
- R2: The data bus is driven only while chip enable and output enable are low, write enable is high, and the controller is in read or verify mode. At all other times it is high-impedance.
- R3: A write cycle is taken once, at the end of the combined low strobe of chip enable and write enable. In read mode, a write of 40h enters program setup, and the next write cycle supplies the target address and data byte.
- R4: The internal program step lasts PROG_CYCLES clocks. At its end the stored byte becomes the old byte ANDed with the written data. While the step runs, and afterwards until a verify command, reads are high-impedance.
- R5: A write of C0h after a completed program step enters verify. In verify, output enable drives the byte at the latched program address, whatever address is presented.
- R6: The latched program address stays constant from the program write until verify mode is left.
- R7: Two consecutive write cycles of FFh return the controller to read mode from any state. A program step cancelled this way leaves the array unchanged.
- R8: A single FFh write followed by a write of any other value does not cancel anything, and the second value is decoded normally.
- R9: In read mode, any command byte other than 40h and 20h leaves the controller in read mode.
- R10: In read mode, a write of 20h enters an erase-setup state. That state holds the bus high-impedance until it is cancelled by R7.
- R11: A write cycle in verify mode ends the verify and is decoded as a read-mode command, so 40h starts a new program setup directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| data | inout | 8 | Bidirectional data bus |

## Verification
The bench programs every address twice with arithmetic patterns, so a design that overwrote instead of ANDing shows a wrong second value. It runs verify with a presented address that differs from the latched one, which exposes a design that reads from the live address. Cancellation is tried from setup, mid-program and erase-setup, and the bench checks that the cancelled target byte is unchanged: a design that committed the write early, or that needed no second FFh, fails there. A lone FFh followed by 40h, and a sweep of all 256 read-mode command values, catch a pending-cancel flag that never clears or a decoder that leaves read mode on stray bytes.

// File: rtl/fcc_pkg.sv
// Shared mode encoding and command byte values for the flash command controller.
package fcc_pkg;
    typedef enum logic [2:0] {
        ST_READ,
        ST_PSETUP,
        ST_PROG,
        ST_PDONE,
        ST_VERIFY,
        ST_ESETUP
    } mode_e;

    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_VERIFY = 8'hC0;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_ONES   = 8'hFF;
endpackage

// File: rtl/fcc_bus_sync.sv
// Brings the asynchronous host strobes, address and data into the clock domain.
// Emits a one-cycle pulse when a combined CE/WE low strobe ends, with the
// address and data seen on the bus at the same synchronised stage.
// Assumes the host keeps address and data stable for two clocks after the strobe.
module fcc_bus_sync #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic              stb_s1, stb_s2, stb_s3;
    logic [ADDR_W-1:0] addr_s1, addr_s2;
    logic [7:0]        data_s1, data_s2;

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_s1  <= 1'b0;
            stb_s2  <= 1'b0;
            stb_s3  <= 1'b0;
            addr_s1 <= '0;
            addr_s2 <= '0;
            data_s1 <= '0;
            data_s2 <= '0;
        end else begin
            stb_s1  <= ~ce_n & ~we_n;
            stb_s2  <= stb_s1;
            stb_s3  <= stb_s2;
            addr_s1 <= addr;
            addr_s2 <= addr_s1;
            data_s1 <= din;
            data_s2 <= data_s1;
        end
    end

    // End of the strobe marks the write cycle.
    assign wr_pulse = stb_s3 & ~stb_s2;
    assign wr_addr  = addr_s2;
    assign wr_data  = data_s2;

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/fcc_seq.sv
// Command decoder and sequencer: program setup, timed program step, verify,
// erase setup and the double-FFh cancel. Assumes one wr_pulse per host write.
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output mode_e             mode,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              prog_en,
    output logic [7:0]        prog_data
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    mode_e             mode_q, mode_d;
    logic [ADDR_W-1:0] lat_q, lat_d;
    logic [7:0]        ldat_q, ldat_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              pend_q, pend_d;
    logic              cancel;

    assign cancel = wr_pulse && (wr_data == CMD_ONES) && pend_q;

    // Next-state decode for mode, latches, program timer and pending cancel.
    always_comb begin
        mode_d  = mode_q;
        lat_d   = lat_q;
        ldat_d  = ldat_q;
        cnt_d   = cnt_q;
        prog_en = 1'b0;
        pend_d  = pend_q;
        if (wr_pulse) pend_d = (wr_data == CMD_ONES) && !pend_q;
        case (mode_q)
            ST_READ: if (wr_pulse) begin
                if (wr_data == CMD_PROG)       mode_d = ST_PSETUP;
                else if (wr_data == CMD_ERASE) mode_d = ST_ESETUP;
            end
            ST_PSETUP: if (wr_pulse) begin
                lat_d  = wr_addr;
                ldat_d = wr_data;
                cnt_d  = CNT_W'(PROG_CYCLES - 1);
                mode_d = ST_PROG;
            end
            ST_PROG: begin
                if (cnt_q == '0) begin
                    prog_en = 1'b1;
                    mode_d  = ST_PDONE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_PDONE: if (wr_pulse) begin
                if (wr_data == CMD_VERIFY)    mode_d = ST_VERIFY;
                else if (wr_data == CMD_PROG) mode_d = ST_PSETUP;
            end
            ST_VERIFY: if (wr_pulse) begin
                if (wr_data == CMD_PROG)       mode_d = ST_PSETUP;
                else if (wr_data == CMD_ERASE) mode_d = ST_ESETUP;
                else                           mode_d = ST_READ;
            end
            default: ;
        endcase
        if (cancel) begin
            mode_d  = ST_READ;
            prog_en = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ST_READ;
            lat_q  <= '0;
            ldat_q <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            lat_q  <= lat_d;
            ldat_q <= ldat_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign mode      = mode_q;
    assign lat_addr  = lat_q;
    assign prog_data = ldat_q;

    assert_reset_read_R1: assert property (@(posedge clk)
        !rst_n |=> mode_q == ST_READ);
    assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q inside {ST_PROG, ST_PDONE, ST_VERIFY}) &&
        ($past(mode_q) inside {ST_PROG, ST_PDONE, ST_VERIFY}) |-> $stable(lat_q));
    assert_cancel_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse && (wr_data == CMD_ONES) && pend_q |=> mode_q == ST_READ);
    assert_prog_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_PROG) && (cnt_q != '0) && !wr_pulse |=> mode_q == ST_PROG);
    assert_stray_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_READ) && wr_pulse && (wr_data != CMD_PROG) &&
        (wr_data != CMD_ERASE) |=> mode_q == ST_READ);
endmodule

// File: rtl/fcc_array.sv
// Register model of the cell array: resets to all-ones, program only clears bits.
module fcc_array #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // Erased state on reset, AND-only update on a program strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (prog_en) begin
            mem_q[prog_addr] <= mem_q[prog_addr] & prog_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

    assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (mem_q[$past(prog_addr)] & ~$past(mem_q[prog_addr])) == 8'h00);
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command controller: bus synchroniser, sequencer, array and
// tri-state read path. Assumes the host follows the write hold rule of fcc_bus_sync.
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [7:0]        data
);
    logic              wr_pulse, prog_en, drive;
    logic [ADDR_W-1:0] wr_addr, lat_addr, rd_addr;
    logic [7:0]        wr_data, prog_data, rd_data;
    mode_e             mode;

    fcc_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .din(data),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fcc_seq #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode), .lat_addr(lat_addr),
        .prog_en(prog_en), .prog_data(prog_data)
    );

    fcc_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .prog_en(prog_en), .prog_addr(lat_addr), .prog_data(prog_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Verify reads the held address; read mode follows the pins.
    assign rd_addr = (mode == ST_VERIFY) ? lat_addr : addr;
    // Output only for an enabled read in a readable mode.
    assign drive   = ~ce_n & ~oe_n & we_n & ((mode == ST_READ) || (mode == ST_VERIFY));
    assign data    = drive ? rd_data : 8'hzz;
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int PC         = 64;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          drv_en = 1'b0;
    logic [7:0]    drv = '0;
    tri1  [7:0]    data_bus;
    int            vectors = 0, miscompares = 0;
    bit            done = 1'b0;
    logic [7:0]    model [DEPTH];

    assign data_bus = drv_en ? drv : 8'hzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PC)) i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data(data_bus)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; drv = d; drv_en = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
        drv_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1 d = data_bus;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Full program + verify; checks verify at a different presented address.
    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        logic [7:0] got;
        host_write(0, 8'h40);
        host_write(a, d);
        model[a] = model[a] & d;
        host_read(a, got);
        check("R4 busy reads high-Z", got, 8'hFF);
        repeat (PC + 2) @(negedge clk);
        host_read(a, got);
        check("R4 done awaits verify", got, 8'hFF);
        host_write(0, 8'hC0);
        host_read(a ^ 4'h5, got);
        check("R5 verify held address", got, model[a]);
        host_write(0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: erased array, read mode
        for (int a = 0; a < DEPTH; a++) begin
            host_read(a[AW-1:0], got);
            check("R1 reset array", got, 8'hFF);
        end

        // R3/R4/R5: program every address, then AND a second pattern
        for (int a = 0; a < DEPTH; a++) program_byte(a[AW-1:0], 8'(a * 29 + 8'h3C));
        for (int a = 0; a < DEPTH; a++) program_byte(a[AW-1:0], 8'(a * 83) ^ 8'hA7);
        for (int a = 0; a < DEPTH; a++) begin
            host_read(a[AW-1:0], got);
            check("R4 stored AND value", got, model[a]);
        end

        // R2: no drive without OE or CE, or during a write
        @(negedge clk); addr = 4'd1; ce_n = 1'b0; oe_n = 1'b1; #1 got = data_bus;
        check("R2 OE high is high-Z", got, 8'hFF);
        ce_n = 1'b1; oe_n = 1'b0; #1 got = data_bus;
        check("R2 CE high is high-Z", got, 8'hFF);
        oe_n = 1'b1;

        // R7: cancel in the middle of a program step
        host_write(0, 8'h40);
        host_write(4'd2, 8'h00);
        host_write(0, 8'hFF);
        host_write(0, 8'hFF);
        repeat (PC + 2) @(negedge clk);
        host_read(4'd2, got);
        check("R7 cancelled program leaves byte", got, model[2]);

        // R7: cancel from program setup (first FFh is harmless data)
        host_write(0, 8'h40);
        host_write(4'd3, 8'hFF);
        host_write(0, 8'hFF);
        host_read(4'd3, got);
        check("R7 cancel from setup", got, model[3]);

        // R10 + R7: erase setup holds bus off until cancelled
        host_write(0, 8'h20);
        host_read(4'd4, got);
        check("R10 erase setup high-Z", got, 8'hFF);
        host_write(0, 8'h40);
        host_read(4'd4, got);
        check("R10 erase setup ignores commands", got, 8'hFF);
        host_write(0, 8'hFF);
        host_write(0, 8'hFF);
        host_read(4'd4, got);
        check("R7 cancel from erase setup", got, model[4]);

        // R8: lone FFh then 40h starts program setup
        host_write(0, 8'hFF);
        host_write(0, 8'h40);
        host_read(4'd5, got);
        check("R8 FFh then 40h enters setup", got, 8'hFF);
        host_write(4'd5, 8'h0F);
        model[5] = model[5] & 8'h0F;
        repeat (PC + 2) @(negedge clk);
        host_write(0, 8'hC0);
        host_read(4'd0, got);
        check("R8 program after lone FFh", got, model[5]);

        // R11: write in verify of 40h goes straight to setup
        host_write(0, 8'h40);
        host_read(4'd6, got);
        check("R11 verify exit to setup", got, 8'hFF);
        host_write(0, 8'hFF);
        host_write(0, 8'hFF);
        host_read(4'd6, got);
        check("R11 back to read", got, model[6]);

        // R9: sweep every read-mode command value
        for (int c = 0; c < 256; c++) begin
            if (c == 8'h40 || c == 8'h20) continue;
            host_write(0, 8'(c));
            host_read(4'd7, got);
            check("R9 stray command stays in read", got, model[7]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule